// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces a doorbell interrupt between the two ports of a shared 4K-word memory. Each port owns one mailbox word at the top of the address space: the left port owns the second-highest address (0xFFE by default) and the right port owns the highest (0xFFF). When the opposite port writes the owner's mailbox word, the owner's active-low interrupt goes low. It stays low until the owner accesses its own mailbox word with output enable asserted. The mailbox words stay ordinary memory whose content software defines. This block only tracks the two flags. It stores no message data and does no collision arbitration.

The block runs on one clock and samples each port's strobes on the rising edge. All port strobes are active low: chip select, write enable (low means write), output enable and the collision indication from the arbiter. Each flag is a two-state machine with the states `FLG_IDLE` (output high) and `FLG_PENDING` (output low). Transition `T_SET` moves `FLG_IDLE` to `FLG_PENDING` on a qualified write by the opposite port. Transition `T_CLR` moves `FLG_PENDING` to `FLG_IDLE` on a qualified access by the owner. When both occur in the same cycle, `T_SET` wins. Every other cycle holds the state. A synchronous reset forces `FLG_IDLE`. When the parameter `INT_EN` is 0, no flag state exists and both outputs stay high.

Top module: `mbx_irq_top`

## Requirements
- R1: In the first cycle after a synchronous reset (rst_n low at a rising edge), both l_irq_n and r_irq_n are 1.
- R2: A rising edge with l_cs_n=0, l_wr_n=0, l_busy_n=1 and l_addr=0xFFF (all ones) drives r_irq_n to 0 after that edge.
- R3: A rising edge with r_cs_n=0, r_oe_n=0 and r_addr=0xFFF, and no set per R2 in the same cycle, drives r_irq_n to 1. The value of r_wr_n has no effect on this clear.
- R4: A right-port write (r_cs_n=0, r_wr_n=0, r_busy_n=1) to 0xFFE drives l_irq_n to 0. A left-port access with l_cs_n=0 and l_oe_n=0 at 0xFFE drives it back to 1, whatever l_wr_n is.
- R5: A write to the opposite mailbox while the writing port's busy input is 0 leaves the target flag unchanged.
- R6: When a set and a clear of the same flag fall in the same cycle, the flag ends up at 0 (pending).
- R7: No other access changes a flag. This covers chip select high, write enable high on the setting side, output enable high on the clearing side, any other address, and a port writing its own mailbox.
- R8: With INT_EN=0, both outputs are 1 in every cycle, whatever the accesses.
- R9: A pending flag stays at 0 through idle cycles and repeated sets until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l_cs_n | input | 1 | Left chip select, active low |
| l_wr_n | input | 1 | Left write enable, 0 = write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_busy_n | input | 1 | Left collision indication, 0 = write inhibited |
| l_addr | input | ADDR_W | Left word address |
| r_cs_n | input | 1 | Right chip select, active low |
| r_wr_n | input | 1 | Right write enable, 0 = write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_busy_n | input | 1 | Right collision indication, 0 = write inhibited |
| r_addr | input | ADDR_W | Right word address |
| l_irq_n | output | 1 | Left-port interrupt, active low |
| r_irq_n | output | 1 | Right-port interrupt, active low |

## Verification
The bound checker checks on every cycle that a qualified write sets the target flag and that a lone qualified access clears it. It also checks that a cycle with neither event leaves the output unchanged, that both outputs are high right after reset, and that a disabled build never drives low. The bench's scenarios are needed to show the ordered behaviours. These are a flag held through idle cycles, set-over-clear when both land together, suppression by the busy input, and the fact that write enable on the clearing side is ignored. A near-exhaustive sweep over every strobe combination with the three address classes compares both outputs against an arithmetic model, cycle by cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic [0:0] {
        FLG_IDLE    = 1'b0,
        FLG_PENDING = 1'b1
    } flag_state_t;

    localparam int unsigned PORT_L = 0;
    localparam int unsigned PORT_R = 1;
    localparam int unsigned NPORTS = 2;
endpackage

// File: rtl/mbx_hit.sv
module mbx_hit #(
    parameter int unsigned         ADDR_W   = 12,
    parameter logic [ADDR_W-1:0]   BOX_ADDR = '1
) (
    input  logic              wr_cs_n,
    input  logic              wr_wr_n,
    input  logic              wr_busy_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              rd_cs_n,
    input  logic              rd_oe_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              set_req,
    output logic              clr_req
);
    logic wr_match;
    logic rd_match;

    always_comb begin
        wr_match = (wr_addr == BOX_ADDR);
        rd_match = (rd_addr == BOX_ADDR);
        set_req  = wr_match && !wr_cs_n && !wr_wr_n && wr_busy_n;
        clr_req  = rd_match && !rd_cs_n && !rd_oe_n;
    end
endmodule

// File: rtl/mbx_flag_fsm.sv
module mbx_flag_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic irq_n
);
    flag_state_t state_q;
    flag_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: begin
                if (set_req) state_d = FLG_PENDING;
            end
            FLG_PENDING: begin
                if (clr_req && !set_req) state_d = FLG_IDLE;
            end
            default: state_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_n = (state_q != FLG_PENDING);
    end
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter bit          INT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_cs_n,
    input  logic              l_wr_n,
    input  logic              l_oe_n,
    input  logic              l_busy_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_cs_n,
    input  logic              r_wr_n,
    input  logic              r_oe_n,
    input  logic              r_busy_n,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_irq_n,
    output logic              r_irq_n
);
    localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] BOX_L = BOX_R - 1'b1;

    logic              cs_n   [NPORTS];
    logic              wr_n   [NPORTS];
    logic              oe_n   [NPORTS];
    logic              busy_n [NPORTS];
    logic [ADDR_W-1:0] addr   [NPORTS];
    logic [NPORTS-1:0] irq_n;

    always_comb begin
        cs_n[PORT_L]   = l_cs_n;    cs_n[PORT_R]   = r_cs_n;
        wr_n[PORT_L]   = l_wr_n;    wr_n[PORT_R]   = r_wr_n;
        oe_n[PORT_L]   = l_oe_n;    oe_n[PORT_R]   = r_oe_n;
        busy_n[PORT_L] = l_busy_n;  busy_n[PORT_R] = r_busy_n;
        addr[PORT_L]   = l_addr;    addr[PORT_R]   = r_addr;
    end

    generate
        if (INT_EN) begin : g_on
            for (genvar d = 0; d < NPORTS; d++) begin : g_dir
                localparam int unsigned       WRITER = NPORTS - 1 - d;
                localparam logic [ADDR_W-1:0] BOX    = (d == PORT_L) ? BOX_L : BOX_R;
                logic set_req;
                logic clr_req;

                mbx_hit #(.ADDR_W(ADDR_W), .BOX_ADDR(BOX)) u_hit (
                    .wr_cs_n   (cs_n[WRITER]),
                    .wr_wr_n   (wr_n[WRITER]),
                    .wr_busy_n (busy_n[WRITER]),
                    .wr_addr   (addr[WRITER]),
                    .rd_cs_n   (cs_n[d]),
                    .rd_oe_n   (oe_n[d]),
                    .rd_addr   (addr[d]),
                    .set_req   (set_req),
                    .clr_req   (clr_req)
                );

                mbx_flag_fsm u_flag (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .set_req (set_req),
                    .clr_req (clr_req),
                    .irq_n   (irq_n[d])
                );
            end
        end else begin : g_off
            assign irq_n = '1;
        end
    endgenerate

    assign l_irq_n = irq_n[PORT_L];
    assign r_irq_n = irq_n[PORT_R];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter bit          INT_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_cs_n,
    input logic              l_wr_n,
    input logic              l_oe_n,
    input logic              l_busy_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_cs_n,
    input logic              r_wr_n,
    input logic              r_oe_n,
    input logic              r_busy_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_irq_n,
    input logic              r_irq_n
);
    localparam logic [ADDR_W-1:0] TOP_A  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] NEXT_A = TOP_A - 1'b1;

    logic armed;
    logic rst_seen;
    logic set_r, clr_r, set_l, clr_l;

    always_comb begin
        set_r = INT_EN && !l_cs_n && !l_wr_n && l_busy_n && (l_addr == TOP_A);
        clr_r = INT_EN && !r_cs_n && !r_oe_n && (r_addr == TOP_A);
        set_l = INT_EN && !r_cs_n && !r_wr_n && r_busy_n && (r_addr == NEXT_A);
        clr_l = INT_EN && !l_cs_n && !l_oe_n && (l_addr == NEXT_A);
    end

    always_ff @(posedge clk) begin
        armed    <= 1'b1;
        rst_seen <= !rst_n;
        // R1
        if (armed && rst_seen) begin
            reset_idle_chk: assert (l_irq_n && r_irq_n);
        end
        // R8
        if (armed && !INT_EN) begin
            disabled_high_chk: assert (l_irq_n && r_irq_n);
        end
    end

    // R2
    r_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_r |=> !r_irq_n);
    // R4
    l_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_l |=> !l_irq_n);
    // R3
    r_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_r && !set_r) |=> r_irq_n);
    // R4
    l_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_l && !set_l) |=> l_irq_n);
    // R7
    r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_r && !clr_r) |=> $stable(r_irq_n));
    // R7
    l_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_l && !clr_l) |=> $stable(l_irq_n));
endmodule

bind mbx_irq_top mbx_irq_chk #(.ADDR_W(ADDR_W), .INT_EN(INT_EN)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n), .l_busy_n(l_busy_n), .l_addr(l_addr),
    .r_cs_n(r_cs_n), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n), .r_busy_n(r_busy_n), .r_addr(r_addr),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
);

// File: tb/mbx_irq_top_tb.sv
`timescale 1ns/1ps
module mbx_irq_top_tb;
    localparam int unsigned ADDR_W = 12;
    localparam logic [ADDR_W-1:0] A_R = 12'hFFF;
    localparam logic [ADDR_W-1:0] A_L = 12'hFFE;
    localparam logic [ADDR_W-1:0] A_X = 12'h5A5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_cs_n, l_wr_n, l_oe_n, l_busy_n;
    logic r_cs_n, r_wr_n, r_oe_n, r_busy_n;
    logic [ADDR_W-1:0] l_addr, r_addr;
    logic l_irq_n, r_irq_n, l_irq_off, r_irq_off;

    int tests = 0;
    int fails = 0;
    bit exp_l = 1'b1;
    bit exp_r = 1'b1;

    always #5 clk = ~clk;

    mbx_irq_top #(.ADDR_W(ADDR_W), .INT_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .l_cs_n(l_cs_n), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n), .l_busy_n(l_busy_n), .l_addr(l_addr),
        .r_cs_n(r_cs_n), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n), .r_busy_n(r_busy_n), .r_addr(r_addr),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    mbx_irq_top #(.ADDR_W(ADDR_W), .INT_EN(1'b0)) u_dut_off (
        .clk(clk), .rst_n(rst_n),
        .l_cs_n(l_cs_n), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n), .l_busy_n(l_busy_n), .l_addr(l_addr),
        .r_cs_n(r_cs_n), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n), .r_busy_n(r_busy_n), .r_addr(r_addr),
        .l_irq_n(l_irq_off), .r_irq_n(r_irq_off)
    );

    task automatic check(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic lc, input logic lw, input logic lo, input logic lb,
                         input logic [ADDR_W-1:0] la,
                         input logic rc, input logic rw, input logic ro, input logic rb,
                         input logic [ADDR_W-1:0] ra);
        @(negedge clk);
        l_cs_n = lc; l_wr_n = lw; l_oe_n = lo; l_busy_n = lb; l_addr = la;
        r_cs_n = rc; r_wr_n = rw; r_oe_n = ro; r_busy_n = rb; r_addr = ra;
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        drive(1, 1, 1, 1, A_X, 1, 1, 1, 1, A_X);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        l_cs_n = 1; l_wr_n = 1; l_oe_n = 1; l_busy_n = 1; l_addr = A_X;
        r_cs_n = 1; r_wr_n = 1; r_oe_n = 1; r_busy_n = 1; r_addr = A_X;
        repeat (3) @(posedge clk);
        #2;
        check("R1 left", l_irq_n, 1'b1);
        check("R1 right", r_irq_n, 1'b1);
        @(negedge clk) rst_n = 1'b1;

        drive(0, 0, 1, 1, A_R, 1, 1, 1, 1, A_X);
        check("R2 set right", r_irq_n, 1'b0);
        check("R2 left untouched", l_irq_n, 1'b1);
        idle(); idle();
        check("R9 hold idle", r_irq_n, 1'b0);
        drive(0, 0, 1, 1, A_R, 1, 1, 1, 1, A_X);
        check("R9 repeat set", r_irq_n, 1'b0);
        drive(1, 1, 1, 1, A_X, 0, 1, 1, 1, A_R);
        check("R7 oe high no clear", r_irq_n, 1'b0);
        drive(1, 1, 1, 1, A_X, 0, 0, 0, 1, A_R);
        check("R3 clear with wr low", r_irq_n, 1'b1);
        drive(0, 0, 1, 1, A_R, 1, 1, 1, 1, A_X);
        drive(1, 1, 1, 1, A_X, 0, 1, 0, 1, A_R);
        check("R3 clear with wr high", r_irq_n, 1'b1);

        drive(1, 1, 1, 1, A_X, 0, 0, 1, 1, A_L);
        check("R4 set left", l_irq_n, 1'b0);
        drive(0, 1, 0, 1, A_L, 1, 1, 1, 1, A_X);
        check("R4 clear left", l_irq_n, 1'b1);

        drive(0, 0, 1, 0, A_R, 1, 1, 1, 1, A_X);
        check("R5 left busy blocks set", r_irq_n, 1'b1);
        drive(1, 1, 1, 1, A_X, 0, 0, 1, 0, A_L);
        check("R5 right busy blocks set", l_irq_n, 1'b1);
        drive(0, 0, 1, 1, A_R, 1, 1, 1, 1, A_X);
        drive(1, 1, 1, 1, A_X, 0, 0, 1, 1, A_R);
        drive(1, 1, 1, 1, A_X, 0, 1, 1, 0, A_X);
        check("R5 busy leaves pending", r_irq_n, 1'b0);
        drive(1, 1, 1, 1, A_X, 0, 1, 0, 1, A_R);

        drive(0, 0, 1, 1, A_R, 0, 1, 0, 1, A_R);
        check("R6 set beats clear from idle", r_irq_n, 1'b0);
        drive(0, 0, 1, 1, A_R, 0, 1, 0, 1, A_R);
        check("R6 set beats clear when pending", r_irq_n, 1'b0);
        drive(1, 1, 1, 1, A_X, 0, 1, 0, 1, A_R);

        drive(0, 0, 1, 1, A_L, 0, 0, 1, 1, A_R);
        check("R7 own-box write left", l_irq_n, 1'b1);
        check("R7 own-box write right", r_irq_n, 1'b1);
        drive(0, 0, 1, 1, A_X, 1, 0, 1, 1, A_L);
        check("R7 other address", r_irq_n, 1'b1);
        check("R7 cs high", l_irq_n, 1'b1);
        drive(0, 1, 1, 1, A_R, 1, 1, 1, 1, A_X);
        check("R7 wr high no set", r_irq_n, 1'b1);
        check("R8 off left", l_irq_off, 1'b1);
        check("R8 off right", r_irq_off, 1'b1);

        exp_l = l_irq_n;
        exp_r = r_irq_n;
        for (int pass = 0; pass < 2; pass++) begin
            for (int idx = 0; idx < 2304; idx++) begin
                int ls;
                int rs;
                logic [ADDR_W-1:0] la;
                logic [ADDR_W-1:0] ra;
                bit sr, cr, sl, cl;
                ls = (idx + pass * 7) % 48;
                rs = idx / 48;
                la = (ls / 16 == 0) ? A_R : (ls / 16 == 1) ? A_L : A_X;
                ra = (rs / 16 == 0) ? A_R : (rs / 16 == 1) ? A_L : A_X;
                sr = (ls % 2 == 0) && ((ls / 2) % 2 == 0) && ((ls / 8) % 2 == 1) && (la == A_R);
                cr = (rs % 2 == 0) && ((rs / 4) % 2 == 0) && (ra == A_R);
                sl = (rs % 2 == 0) && ((rs / 2) % 2 == 0) && ((rs / 8) % 2 == 1) && (ra == A_L);
                cl = (ls % 2 == 0) && ((ls / 4) % 2 == 0) && (la == A_L);
                exp_r = sr ? 1'b0 : (cr ? 1'b1 : exp_r);
                exp_l = sl ? 1'b0 : (cl ? 1'b1 : exp_l);
                drive(ls[0], ls[1], ls[2], ls[3], la, rs[0], rs[1], rs[2], rs[3], ra);
                check("R2/R3/R5/R6/R7 sweep right", r_irq_n, exp_r);
                check("R4/R5/R6/R7 sweep left", l_irq_n, exp_l);
                check("R8 sweep off", l_irq_off & r_irq_off, 1'b1);
            end
        end

        drive(0, 0, 1, 1, A_R, 0, 0, 1, 1, A_L);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #2;
        check("R1 reset clears left", l_irq_n, 1'b1);
        check("R1 reset clears right", r_irq_n, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule